// File: doc/BRIEF.md
# Network Statistics Counter Bank

This block keeps eighteen event counters for a network controller. Each counter has its own single-cycle increment strobe. The strobes come from the transmit and receive frame-completion logic, so a counter moves when a frame has finished on the link, not when its data was fetched. The counters cover:

- good, aborted and errored transmit frames, collisions and deferrals;
- good and errored receive frames;
- pause frames sent and received, where a pause with time zero counts the same as any other pause.

One counter, for collisions seen during reception, can be held at zero by a parameter for variants that never report it.

Software reads the bank through a command port. There are two commands: a plain dump, and a dump that also clears the counters. When a command is accepted, all counters are copied in the same cycle. The copy is then streamed out as one word per handshake, in ascending byte-offset order, with a four-byte step between words. A one-cycle completion pulse follows the last word.

Increments that arrive while a dump is running are never lost. Counters saturate at all-ones instead of wrapping.

The output stream is valid/ready:
- A word is transferred on each rising edge where both valid and ready are high.
- While valid is high and ready is low, the word and its offset stay unchanged.
- Ready may be held low for any number of cycles.
- The command port has no handshake. A command is taken only when busy is low, and is otherwise dropped.

Top module: `net_stat_bank`

## Requirements
- R1: After reset every counter reads zero, and dump_valid_o, busy_o and dump_done_o are low.
- R2: A high inc_i[k] in a cycle adds one to counter k; strobes on several bits in the same cycle each count independently.
- R3: A counter that holds all-ones stays at all-ones on further strobes.
- R4: A command is accepted on a rising edge where cmd_valid_i is high and busy_o is low. Counter values are captured at that edge, excluding that cycle's strobes. The captured values are then streamed as counter 0 first through counter 17 last, with dump_offset_o equal to four times the counter index.
- R5: While dump_valid_o is high and dump_ready_i is low, dump_data_o and dump_offset_o hold their values; exactly one word advances per handshake.
- R6: busy_o is high from the cycle after acceptance up to and including the dump_done_o cycle. dump_done_o is a single-cycle pulse in the cycle after the last word's handshake, with dump_valid_o low at that time.
- R7: A command with cmd_clear_i=1 (dump-and-reset; 0 selects a plain dump) clears every counter at the acceptance edge. A counter whose strobe is high in that cycle reads one afterwards.
- R8: A plain dump leaves the counters unchanged. Strobes in the acceptance cycle and during streaming are counted and show up in the next dump, but not in the current one.
- R9: A command presented while busy_o is high is ignored: it neither clears the counters nor restarts the stream.
- R10: With TIE_RXCOL_ZERO=1, counter 14 (offset 56) always reads zero whatever its strobe does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_i | input | NUM_CTR | One increment strobe per counter |
| cmd_valid_i | input | 1 | Dump command request |
| cmd_clear_i | input | 1 | 1 = dump-and-reset, 0 = plain dump |
| busy_o | output | 1 | A dump is in progress; commands are ignored |
| dump_valid_o | output | 1 | Output word is valid |
| dump_ready_i | input | 1 | Consumer accepts the word |
| dump_data_o | output | CTR_W | Counter value from the snapshot |
| dump_offset_o | output | OFF_W | Byte offset of the word (4 x index) |
| dump_done_o | output | 1 | One-cycle pulse after the last word |

## Verification
The counting function is driven by a table of strobe masks:
- a single low counter;
- all counters together;
- alternating even and odd patterns;
- grouped nibbles;
- the last counter alone.

Each mask is followed by either kind of dump, with a free-flowing or a stalling consumer. This separates per-counter independence, order and offset errors, and back-pressure slips. Directed cases then fire strobes in the acceptance cycle of a clear, which tells a kept increment from a dropped one. Further directed cases:
- strobes and a stray clear command in the middle of a plain dump, which separates lost counts and an honoured busy command from correct behaviour;
- a long run on one counter, which exposes wrapping;
- the tied receive-collision counter, strobed in several patterns, which shows whether it ever leaves zero.

// File: rtl/nsb_pkg.sv
package nsb_pkg;
  localparam int NSB_BYTES_PER_WORD = 4;
  localparam int NSB_DEF_COUNTERS   = 18;
  localparam int NSB_IDX_RX_COLL    = 14;

  typedef enum logic {
    NSB_IDLE   = 1'b0,
    NSB_STREAM = 1'b1
  } nsb_state_e;
endpackage

// File: rtl/nsb_counter.sv
module nsb_counter #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CTR_W-1:0] cnt_o
);
  localparam logic [CTR_W-1:0] SAT_VAL = '1;

  logic [CTR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      // a strobe coinciding with the clear survives as a count of one
      cnt_q <= inc_i ? CTR_W'(1) : '0;
    end else if (inc_i && (cnt_q != SAT_VAL)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/nsb_dump_seq.sv
module nsb_dump_seq
  import nsb_pkg::*;
#(
  parameter int NUM_CTR = 18,
  parameter int CTR_W   = 32,
  parameter int OFF_W   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [NUM_CTR*CTR_W-1:0] cnt_flat_i,
  input  logic                     ready_i,
  output logic                     valid_o,
  output logic [CTR_W-1:0]         data_o,
  output logic [OFF_W-1:0]         offset_o,
  output logic                     done_o,
  output logic                     busy_o
);
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CTR - 1);
  localparam int SHIFT = $clog2(NSB_BYTES_PER_WORD);

  nsb_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic [CTR_W-1:0] snap_q [NUM_CTR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= NSB_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == NSB_IDLE) begin
        if (start_i) begin
          state_q <= NSB_STREAM;
          idx_q   <= '0;
        end
      end else if (ready_i) begin
        if (idx_q == LAST_IDX) begin
          state_q <= NSB_IDLE;
          done_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // snapshot storage needs no reset: it is only read while streaming
  always_ff @(posedge clk) begin
    if ((state_q == NSB_IDLE) && start_i) begin
      for (int k = 0; k < NUM_CTR; k++) begin
        snap_q[k] <= cnt_flat_i[k*CTR_W +: CTR_W];
      end
    end
  end

  assign valid_o  = (state_q == NSB_STREAM);
  assign data_o   = snap_q[idx_q];
  assign offset_o = OFF_W'(idx_q) << SHIFT;
  assign done_o   = done_q;
  assign busy_o   = (state_q == NSB_STREAM) | done_q;
endmodule

// File: rtl/net_stat_bank.sv
module net_stat_bank
  import nsb_pkg::*;
#(
  parameter int NUM_CTR        = NSB_DEF_COUNTERS,
  parameter int CTR_W          = 32,
  parameter int OFF_W          = $clog2(NUM_CTR * NSB_BYTES_PER_WORD),
  parameter bit TIE_RXCOL_ZERO = 1'b0,
  parameter int RXCOL_IDX      = NSB_IDX_RX_COLL
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] inc_i,
  input  logic               cmd_valid_i,
  input  logic               cmd_clear_i,
  output logic               busy_o,
  output logic               dump_valid_o,
  input  logic               dump_ready_i,
  output logic [CTR_W-1:0]   dump_data_o,
  output logic [OFF_W-1:0]   dump_offset_o,
  output logic               dump_done_o
);
  logic                     accept;
  logic                     clear_now;
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;

  assign accept    = cmd_valid_i && !busy_o;
  assign clear_now = accept && cmd_clear_i;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    localparam bit TIED = TIE_RXCOL_ZERO && (g == RXCOL_IDX);
    nsb_counter #(.CTR_W(CTR_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (inc_i[g] & ~TIED),
      .clr_i (clear_now),
      .cnt_o (cnt_flat[g*CTR_W +: CTR_W])
    );
  end

  nsb_dump_seq #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .OFF_W   (OFF_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (accept),
    .cnt_flat_i (cnt_flat),
    .ready_i    (dump_ready_i),
    .valid_o    (dump_valid_o),
    .data_o     (dump_data_o),
    .offset_o   (dump_offset_o),
    .done_o     (dump_done_o),
    .busy_o     (busy_o)
  );
endmodule

// File: rtl/nsb_checker.sv
module nsb_checker #(
  parameter int NUM_CTR = 18,
  parameter int CTR_W   = 32,
  parameter int OFF_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             dump_valid_o,
  input logic             dump_ready_i,
  input logic [CTR_W-1:0] dump_data_o,
  input logic [OFF_W-1:0] dump_offset_o,
  input logic             dump_done_o
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'((NUM_CTR - 1) * 4);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_valid_o && !dump_ready_i) |=> (dump_valid_o && $stable(dump_data_o) && $stable(dump_offset_o))); // R5
  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_valid_o && dump_ready_i && (dump_offset_o != LAST_OFF)) |=> (dump_valid_o && (dump_offset_o == $past(dump_offset_o) + OFF_W'(4)))); // R4
  AST_FIRST_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dump_valid_o) |-> (dump_offset_o == '0)); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_valid_o && dump_ready_i && (dump_offset_o == LAST_OFF)) |=> (dump_done_o && !dump_valid_o)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dump_done_o |=> !dump_done_o); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!dump_valid_o && !dump_done_o)); // R6
endmodule

bind net_stat_bank nsb_checker #(
  .NUM_CTR (NUM_CTR),
  .CTR_W   (CTR_W),
  .OFF_W   (OFF_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy_o        (busy_o),
  .dump_valid_o  (dump_valid_o),
  .dump_ready_i  (dump_ready_i),
  .dump_data_o   (dump_data_o),
  .dump_offset_o (dump_offset_o),
  .dump_done_o   (dump_done_o)
);

// File: tb/net_stat_bank_tb.sv
`timescale 1ns/1ps
module net_stat_bank_tb;
  localparam int NC    = 18;
  localparam int CW    = 8;
  localparam int OW    = $clog2(NC * 4);
  localparam int TIEDX = 14;
  localparam logic [CW-1:0] MAXV = '1;

  typedef struct packed {
    logic [17:0] mask;
    logic [8:0]  reps;
    logic        clr;
    logic        stall;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{18'h00001, 9'd3, 1'b0, 1'b0},
    '{18'h3FFFF, 9'd2, 1'b0, 1'b1},
    '{18'h2AAAA, 9'd5, 1'b1, 1'b0},
    '{18'h15555, 9'd7, 1'b0, 1'b1},
    '{18'h0F0F0, 9'd4, 1'b1, 1'b1},
    '{18'h20000, 9'd9, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] inc = '0;
  logic          cmd_valid = 1'b0;
  logic          cmd_clear = 1'b0;
  logic          busy, dvalid, dready, ddone;
  logic [CW-1:0] ddata;
  logic [OW-1:0] doff;

  int  nchk = 0;
  int  nfail = 0;
  bit  finished = 1'b0;
  logic [CW-1:0] model [NC];
  logic [CW-1:0] snap  [NC];

  always #2 clk = ~clk;

  net_stat_bank #(
    .NUM_CTR(NC), .CTR_W(CW), .TIE_RXCOL_ZERO(1'b1), .RXCOL_IDX(TIEDX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .inc_i(inc), .cmd_valid_i(cmd_valid),
    .cmd_clear_i(cmd_clear), .busy_o(busy), .dump_valid_o(dvalid),
    .dump_ready_i(dready), .dump_data_o(ddata), .dump_offset_o(doff),
    .dump_done_o(ddone)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] step(input int j, input logic [CW-1:0] cur,
                                          input bit hit, input bit clr);
    if (j == TIEDX) return '0;
    if (clr) return hit ? CW'(1) : '0;
    if (hit && cur != MAXV) return cur + 1'b1;
    return cur;
  endfunction

  task automatic pulse(input logic [NC-1:0] mask, input int reps);
    for (int r = 0; r < reps; r++) begin
      @(negedge clk);
      inc = mask;
      for (int j = 0; j < NC; j++) model[j] = step(j, model[j], mask[j], 1'b0);
    end
    @(negedge clk);
    inc = '0;
  endtask

  task automatic dump_chk(input bit clr, input bit stall, input logic [NC-1:0] coinc,
                          input logic [NC-1:0] midinc, input bit inject, input string tag);
    int  idx = 0;
    int  cyc = 0;
    bit  injd = 1'b0;
    bit  incd = 1'b0;
    bit  rdy;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_clear = clr;
    inc = coinc;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_clear = 1'b0;
    inc = '0;
    for (int j = 0; j < NC; j++) begin
      snap[j]  = model[j];
      model[j] = step(j, model[j], coinc[j], clr);
    end
    chk(busy == 1'b1, "R6", "busy after accept", busy, 1);
    while (idx < NC && cyc < 400) begin
      rdy = stall ? cyc[0] : 1'b1;
      dready = rdy;
      inc = '0;
      cmd_valid = 1'b0;
      if (idx == 3 && !incd) begin
        incd = 1'b1;
        inc = midinc;
        for (int j = 0; j < NC; j++) model[j] = step(j, model[j], midinc[j], 1'b0);
      end
      if (inject && idx == 5 && !injd) begin
        injd = 1'b1;
        cmd_valid = 1'b1;
        cmd_clear = 1'b1;
      end
      if (dvalid && rdy) begin
        chk(ddata == snap[idx], (idx == TIEDX) ? "R10" : tag, $sformatf("word %0d", idx),
            ddata, snap[idx]);
        chk(doff == OW'(idx * 4), "R4", $sformatf("offset of word %0d", idx), doff, idx * 4);
        idx++;
      end
      @(negedge clk);
      cyc++;
    end
    inc = '0;
    cmd_valid = 1'b0;
    cmd_clear = 1'b0;
    dready = 1'b0;
    chk(idx == NC, "R5", "words received", idx, NC);
    chk(ddone == 1'b1 && dvalid == 1'b0, "R6", "done pulse after last word", ddone, 1);
    @(negedge clk);
    chk(ddone == 1'b0 && busy == 1'b0, "R6", "done single and busy released", {ddone, busy}, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL R6 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    dready = 1'b0;
    for (int j = 0; j < NC; j++) model[j] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dvalid && !busy && !ddone, "R1", "outputs idle after reset", {dvalid, busy, ddone}, 0);
    dump_chk(1'b0, 1'b0, '0, '0, 1'b0, "R1");

    // table-driven main function
    for (int v = 0; v < 6; v++) begin
      pulse(VEC[v].mask, int'(VEC[v].reps));
      dump_chk(VEC[v].clr, VEC[v].stall, '0, '0, 1'b0,
               VEC[v].stall ? "R5" : (VEC[v].clr ? "R7" : "R2"));
    end

    // R7: strobe in the clearing cycle survives as one
    pulse(18'h3FFFF, 2);
    dump_chk(1'b1, 1'b0, 18'h04003, '0, 1'b0, "R7");
    dump_chk(1'b0, 1'b0, '0, '0, 1'b0, "R7");

    // R8 / R9: strobes around a plain dump and a stray clear while busy
    pulse(18'h00F00, 3);
    dump_chk(1'b0, 1'b1, 18'h00100, 18'h00201, 1'b1, "R8");
    dump_chk(1'b0, 1'b0, '0, '0, 1'b0, "R9");

    // R3: saturation at all-ones
    pulse(18'h00004, 300);
    dump_chk(1'b0, 1'b0, '0, '0, 1'b0, "R3");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule